// File: doc/BRIEF.md
# Serial Two's Complement Negator

This block negates a binary word that arrives one bit per clock, least significant bit first, and emits the negated word in the same order and on the same cycles. It does not use an adder. It uses a two-state Mealy machine. In the Copying state, input bits pass through unchanged up to and including the first 1. After that bit the machine moves to the Inverting state, and every later bit of the word leaves complemented.

A valid qualifier marks the cycles that carry a bit. The machine advances only on those cycles, so a stream may contain idle gaps. A start-of-word strobe comes with the first bit of each word and returns the machine to Copying before that bit is used. A new word may therefore follow the previous one with no idle cycle.

The negated bit is produced combinationally from the current state and the incoming bit. A registered copy of the bit and of its qualifier is also provided one cycle later.

States and transitions:

- COPY --(valid, bit 0)--> COPY
- COPY --(valid, bit 1)--> INVERT
- INVERT --(valid)--> INVERT
- any state --(valid with start strobe)--> treated as COPY for that bit, then follows the COPY transitions
- any state --(no valid)--> unchanged

Top module: `serial_negator`

## Requirements
- R1: After reset the registered outputs `neg_valid_q` and `neg_bit_q` are 0. The machine is in COPY, so a first 1 with no start strobe still comes out as 1.
- R2: In COPY, a valid 0 leaves as 0 and the machine stays in COPY.
- R3: In COPY, a valid 1 leaves as 1 and the machine moves to INVERT.
- R4: In INVERT, every valid bit leaves complemented and the machine stays in INVERT until a start strobe arrives.
- R5: When `word_start` is high together with `bit_valid`, that bit is handled as in COPY, whatever the earlier state.
- R6: When `bit_valid` is low, the state does not change, whatever `bit_in` or `word_start` carry.
- R7: `neg_valid` equals `bit_valid` in the same cycle. `neg_bit` is `bit_in` XOR (effective state is INVERT), with no register in the path.
- R8: One cycle after a valid bit, `neg_valid_q` is 1 and `neg_bit_q` equals that cycle's `neg_bit`. After a cycle without a valid bit, `neg_valid_q` is 0 and `neg_bit_q` holds its value.
- R9: For a word of N bits, the output bits form (2^N - value) mod 2^N. An all-zero word comes out unchanged, and 1 followed by N-1 zeros (most significant bit only) maps to itself.
- R10: `word_start` sampled while `bit_valid` is low has no effect on later bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Qualifies `bit_in` and `word_start` |
| word_start | input | 1 | Marks the first bit of a word |
| bit_in | input | 1 | Serial input bit, least significant bit first |
| neg_valid | output | 1 | Combinational output qualifier |
| neg_bit | output | 1 | Combinational negated bit |
| neg_valid_q | output | 1 | Registered output qualifier |
| neg_bit_q | output | 1 | Registered negated bit |

## Verification
The block has no sizing parameters, so the bench chooses the word length per word instead. Lengths run from 1 to 32 bits. This covers single-bit words, words whose only 1 is the last bit, and words whose first 1 is bit 0. Random idle gaps that carry stray start strobes and data are placed inside words, so the hold rule and the ignored-strobe rule are tested in both states. Back-to-back words that start while the machine is in INVERT show that the strobe takes effect on the same bit it marks.

// File: rtl/negate_pkg.sv
package negate_pkg;
    typedef enum logic {
        NEG_COPY   = 1'b0,
        NEG_INVERT = 1'b1
    } neg_state_e;
endpackage

// File: rtl/negate_fsm.sv
module negate_fsm
    import negate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic word_start,
    input  logic bit_in,
    output logic invert_now
);
    neg_state_e state_r;
    neg_state_e state_eff;
    neg_state_e state_nx;

    // effective state for the bit on the inputs: a valid start strobe re-arms COPY
    always_comb begin
        state_eff = (bit_valid && word_start) ? NEG_COPY : state_r;
    end

    always_comb begin
        state_nx = state_eff;
        unique case (state_eff)
            NEG_COPY:   state_nx = bit_in ? NEG_INVERT : NEG_COPY;
            NEG_INVERT: state_nx = NEG_INVERT;
            default:    state_nx = NEG_COPY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_r <= NEG_COPY;
        else if (bit_valid)
            state_r <= state_nx;
    end

    always_comb begin
        invert_now = (state_eff == NEG_INVERT);
    end

    assert_copy_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !invert_now && !bit_in) |=> (state_r == NEG_COPY));

    assert_first_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !invert_now && bit_in) |=> (state_r == NEG_INVERT));

    assert_stay_invert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !word_start && state_r == NEG_INVERT) |=> (state_r == NEG_INVERT));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid) |=> $stable(state_r));
endmodule

// File: rtl/negate_outreg.sv
module negate_outreg (
    input  logic clk,
    input  logic rst_n,
    input  logic d_valid,
    input  logic d_bit,
    output logic q_valid,
    output logic q_bit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_bit   <= 1'b0;
        end else begin
            q_valid <= d_valid;
            if (d_valid)
                q_bit <= d_bit;
        end
    end

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_valid) |=> (!q_valid && $stable(q_bit)));
endmodule

// File: rtl/serial_negator.sv
module serial_negator (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic word_start,
    input  logic bit_in,
    output logic neg_valid,
    output logic neg_bit,
    output logic neg_valid_q,
    output logic neg_bit_q
);
    logic invert_now;

    negate_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .word_start (word_start),
        .bit_in     (bit_in),
        .invert_now (invert_now)
    );

    always_comb begin
        neg_valid = bit_valid;
        neg_bit   = bit_in ^ invert_now;
    end

    negate_outreg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (neg_valid),
        .d_bit   (neg_bit),
        .q_valid (neg_valid_q),
        .q_bit   (neg_bit_q)
    );

    assert_start_copies_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && word_start) |-> (neg_bit == bit_in));

    assert_start_one_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && word_start && bit_in) |=> (neg_valid_q && neg_bit_q));
endmodule

// File: tb/tb_serial_negator.sv
module tb_serial_negator;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic word_start = 1'b0;
    logic bit_in = 1'b0;
    logic neg_valid, neg_bit, neg_valid_q, neg_bit_q;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic last_q;

    always #4 clk = ~clk;

    serial_negator dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .word_start(word_start),
        .bit_in(bit_in), .neg_valid(neg_valid), .neg_bit(neg_bit),
        .neg_valid_q(neg_valid_q), .neg_bit_q(neg_bit_q)
    );

    function automatic logic [31:0] negate_ref(input logic [31:0] v, input int n);
        logic [31:0] m;
        m = (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        return ((~v) + 32'd1) & m;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // one idle cycle with random stray data and strobe (R6, R10, R8 hold)
    task automatic idle_cycle();
        @(negedge clk);
        bit_valid  = 1'b0;
        word_start = 1'($urandom);
        bit_in     = 1'($urandom);
        #1;
        check("R7 idle neg_valid", neg_valid, 1'b0);
        @(posedge clk); #1;
        check("R8 idle valid_q", neg_valid_q, 1'b0);
        check("R8 idle hold bit_q", neg_bit_q, last_q);
    endtask

    task automatic send_word(input logic [31:0] v, input int n, input bit use_start,
                             input bit gaps);
        logic [31:0] exp_w, got_w;
        bit seen_one;
        exp_w = negate_ref(v, n);
        got_w = '0;
        seen_one = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (gaps && ($urandom % 4 == 0)) idle_cycle();
            @(negedge clk);
            bit_valid  = 1'b1;
            word_start = use_start && (i == 0);
            bit_in     = v[i];
            #1;
            check("R7 neg_valid", neg_valid, 1'b1);
            if (!seen_one && !v[i]) check("R2 copy zero", neg_bit, exp_w[i]);
            else if (!seen_one)     check("R3 first one", neg_bit, exp_w[i]);
            else                    check("R4 invert", neg_bit, exp_w[i]);
            if (v[i]) seen_one = 1'b1;
            got_w[i] = neg_bit;
            @(posedge clk); #1;
            check("R8 valid_q", neg_valid_q, 1'b1);
            check("R8 bit_q", neg_bit_q, exp_w[i]);
            last_q = exp_w[i];
        end
        total++;
        if (got_w !== exp_w) begin
            bad++;
            $display("FAIL R9 word n=%0d v=%h act=%h exp=%h", n, v, got_w, exp_w);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        last_q = 1'b0;
        #20;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset valid_q", neg_valid_q, 1'b0);
        check("R1 reset bit_q", neg_bit_q, 1'b0);
        // R1: first word after reset, no start strobe, still starts in COPY
        send_word(32'h0000_0006, 4, 1'b0, 1'b0);
        // R5: back-to-back word starting while in INVERT
        send_word(32'h0000_0004, 4, 1'b1, 1'b0);
        // R9: all zeros and most-negative values map to themselves
        send_word(32'h0000_0000, 8, 1'b1, 1'b0);
        send_word(32'h0000_0080, 8, 1'b1, 1'b0);
        send_word(32'h8000_0000, 32, 1'b1, 1'b0);
        send_word(32'hFFFF_FFFF, 32, 1'b1, 1'b0);
        send_word(32'h0000_0001, 1, 1'b1, 1'b0);
        send_word(32'h0000_0000, 1, 1'b1, 1'b0);
        // R6, R10: stray strobe during an idle cycle in INVERT is ignored
        send_word(32'h0000_0001, 1, 1'b1, 1'b0);
        @(negedge clk);
        bit_valid = 1'b0; word_start = 1'b1; bit_in = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        bit_valid = 1'b1; word_start = 1'b0; bit_in = 1'b0;
        #1;
        check("R10 strobe without valid ignored", neg_bit, 1'b1);
        @(posedge clk); #1;
        last_q = 1'b1;
        // random words with random gaps
        for (int w = 0; w < 300; w++) begin
            int n;
            logic [31:0] v;
            n = 1 + int'($urandom % 32);
            v = $urandom;
            if ($urandom % 5 == 0) v = v & ~((32'd1 << (n - 1)) - 32'd1);
            send_word(v, n, 1'b1, 1'b1);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule